// File: doc/BRIEF.md
# Bridge Function Interrupt Message Generator

This block gathers the interrupt requests of one bridge function in a switch port and turns them into interrupt message requests. Each request sets a sticky bit in a status register. A mask register gates those bits, and the unmasked bits are ORed into one interrupt condition. When the condition rises, the block requests an MSI or an Assert_INTA message, depending on the MSI-enable and INTx-disable inputs. When the condition falls in legacy mode, it requests Deassert_INTA. Only the INTA virtual wire is ever signalled.

Software reaches both registers through a small read/write port: address 0 is the status register (write 1 to clear) and address 1 is the mask register. Message requests leave on a valid/ready handshake with one request outstanding. Legacy assert and deassert events that occur while the output is stalled are kept in order in a two-entry queue, so an assert that is still pending is always followed by its deassert.

The parameter `UPSTREAM` selects the source set. When it is 0 (downstream port): bit 0 is hot-plug, bit 1 is link bandwidth status, and bit 2 is autonomous bandwidth status; bit 3 does not exist. When it is 1 (upstream port): bit 0 is switch event, bit 1 is failover started, bit 2 is failover completed, and bit 3 is temperature alarm.

The controller runs as a state machine with four states:

| State | Meaning |
|---|---|
| ST_IDLE | No request is presented. |
| ST_SEND_ASRT | An Assert_INTA request is presented. |
| ST_SEND_DSRT | A Deassert_INTA request is presented. |
| ST_SEND_MSI | An MSI request is presented. |

Its transitions are:
- ST_IDLE goes to ST_SEND_ASRT or ST_SEND_DSRT when a legacy event is queued. The oldest entry decides which.
- ST_IDLE goes to ST_SEND_MSI when an MSI is pending and the legacy queue is empty.
- Each sending state returns to ST_IDLE on the cycle its request is accepted.

Top module: `brg_irq_gen`

## Requirements
- R1: After reset, the status register reads 0. The mask register reads all ones over the implemented bits: 0x7 for a downstream port, 0xF for an upstream port. `msg_valid` is low.
- R2: A source event sets its status bit, and the bit stays set until it is cleared. A status bit that is not implemented (bit 3 on a downstream port) always reads 0.
- R3: Writing to address 0 clears every status bit whose data bit is 1. If a source event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R4: A masked status bit raises no message. Unmasking a status bit that is already set raises the condition, which then produces a message.
- R5: While a source's status bit is set, further events from that source produce no new message.
- R6: When the condition rises with `msi_en`=1, exactly one request with `msg_type`=1 (MSI) is issued, whatever the value of `intx_dis`.
- R7: When the condition rises with `msi_en`=0 and `intx_dis`=0, a request with `msg_type`=2 (Assert_INTA) is issued. With `msi_en`=0 and `intx_dis`=1, nothing is issued.
- R8: When the condition falls, whether because the causing bits are cleared or masked, and `msi_en`=0 and `intx_dis`=0, a request with `msg_type`=3 (Deassert_INTA) is issued. In any other mode, nothing is issued when the condition falls.
- R9: On a downstream port, status bit 1 can set only when `bw_note_en`=1, and status bit 2 can set only when `abw_note_en`=1.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and `msg_type` holds its value. An Assert_INTA that is still pending when the condition falls is followed by a Deassert_INTA, in that order.
- R11: With `UPSTREAM`=1, four sources exist, and an event on bit 3 sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | SRC_W | One-cycle service requests, one bit per source |
| bw_note_en | input | 1 | Notification enable for link bandwidth status (downstream port) |
| abw_note_en | input | 1 | Notification enable for autonomous bandwidth status (downstream port) |
| msi_en | input | 1 | MSI enable |
| intx_dis | input | 1 | Legacy interrupt disable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; `reg_rdata` is 0 when this is low |
| reg_addr | input | ADDR_W | Register select: 0 is status, 1 is mask |
| reg_wdata | input | SRC_W | Write data |
| reg_rdata | output | SRC_W | Read data, combinational from `reg_addr` |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted when high together with `msg_valid` |
| msg_type | output | 2 | 1 = MSI, 2 = Assert_INTA, 3 = Deassert_INTA |

## Verification
The assertions take for granted that `msg_ready` only matters while `msg_valid` is high, and that register writes and source events are synchronous one-cycle pulses. The stimulus drives every input shortly after a rising edge and never toggles `msi_en` or `intx_dis` while a message for the current condition is still in flight. In the stalled case, the stimulus causes exactly one rise and one fall, so the queue of legacy events never has to collapse entries.

// File: rtl/brg_irq_pkg.sv
package brg_irq_pkg;

    // Widest source set; the upstream set uses all four bits.
    localparam int MAX_SRC = 4;

    // Message codes presented on msg_type.
    typedef enum logic [1:0] {
        MSG_NONE = 2'd0,
        MSG_MSI  = 2'd1,
        MSG_ASRT = 2'd2,
        MSG_DSRT = 2'd3
    } msg_kind_t;

    // States of the output controller.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND_MSI,
        ST_SEND_ASRT,
        ST_SEND_DSRT
    } tx_state_t;

endpackage

// File: rtl/brg_irq_capture.sv
module brg_irq_capture #(
    parameter int UPSTREAM = 0,
    parameter int SRC_W    = brg_irq_pkg::MAX_SRC,
    parameter int ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_evt,
    input  logic              bw_note_en,
    input  logic              abw_note_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SRC_W-1:0]  reg_wdata,
    output logic [SRC_W-1:0]  reg_rdata,
    output logic [SRC_W-1:0]  evt_g,
    output logic [SRC_W-1:0]  status_q,
    output logic [SRC_W-1:0]  mask_q,
    output logic              irq_cond
);

    // Number of implemented sources and the mask of implemented bits.
    localparam int NSRC = (UPSTREAM != 0) ? 4 : 3;
    localparam logic [SRC_W-1:0] IMPL = SRC_W'((1 << NSRC) - 1);
    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(1);

    logic [SRC_W-1:0] src_en;
    logic [SRC_W-1:0] clr_vec;
    logic             sts_wr;
    logic             msk_wr;

    assign sts_wr  = reg_wr && (reg_addr == STS_ADDR);
    assign msk_wr  = reg_wr && (reg_addr == MSK_ADDR);
    assign clr_vec = sts_wr ? reg_wdata : '0;

    // Per-source enable: the bandwidth bits of a downstream port are
    // gated by their own notification enables.
    always_comb begin
        for (int i = 0; i < SRC_W; i++) begin
            src_en[i] = IMPL[i];
            if (UPSTREAM == 0 && i == 1) src_en[i] = IMPL[i] & bw_note_en;
            if (UPSTREAM == 0 && i == 2) src_en[i] = IMPL[i] & abw_note_en;
        end
    end

    assign evt_g = src_en & src_evt;

    // One sticky status flop per bit; an event wins over a clear.
    generate
        for (genvar b = 0; b < SRC_W; b++) begin : g_sts
            if (IMPL[b]) begin : g_impl
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        status_q[b] <= 1'b0;
                    end else if (evt_g[b]) begin
                        status_q[b] <= 1'b1;
                    end else if (clr_vec[b]) begin
                        status_q[b] <= 1'b0;
                    end
                end
            end else begin : g_none
                assign status_q[b] = 1'b0;
            end
        end
    endgenerate

    // Mask register: every implemented source starts masked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= IMPL;
        end else if (msk_wr) begin
            mask_q <= reg_wdata & IMPL;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == STS_ADDR)      reg_rdata = status_q;
            else if (reg_addr == MSK_ADDR) reg_rdata = mask_q;
        end
    end

    assign irq_cond = |(status_q & ~mask_q);

endmodule

// File: rtl/brg_irq_edge.sv
module brg_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_cond,
    input  logic msi_en,
    input  logic intx_dis,
    output logic msi_evt,
    output logic intx_evt,
    output logic intx_asrt
);

    logic cond_q;
    logic rise;
    logic fall;
    logic legacy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= irq_cond;
    end

    assign rise      = irq_cond & ~cond_q;
    assign fall      = ~irq_cond & cond_q;
    assign legacy    = ~msi_en & ~intx_dis;

    // MSI only on assertion; the legacy wire follows both edges.
    assign msi_evt   = rise & msi_en;
    assign intx_evt  = (rise | fall) & legacy;
    assign intx_asrt = rise;

endmodule

// File: rtl/brg_irq_tx.sv
module brg_irq_tx
    import brg_irq_pkg::*;
#(
    parameter int QDEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       msi_evt,
    input  logic       intx_evt,
    input  logic       intx_asrt,
    input  logic       msg_ready,
    output logic       msg_valid,
    output logic [1:0] msg_type
);

    localparam int CNT_W = $clog2(QDEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QDEPTH);

    tx_state_t         state_q, state_n;
    logic [QDEPTH-1:0] kind_q, kind_n;     // 1 = assert entry, 0 = deassert
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              msi_pend_q, msi_pend_n;
    logic              accept;
    logic              pop_intx;
    logic              pop_msi;

    assign accept   = msg_valid & msg_ready;
    assign pop_intx = accept & ((state_q == ST_SEND_ASRT) || (state_q == ST_SEND_DSRT));
    assign pop_msi  = accept & (state_q == ST_SEND_MSI);

    // Legacy event queue: pop the presented entry, then append the new one.
    // When full, an event equal to the head cancels the tail pair.
    always_comb begin
        kind_n = kind_q;
        cnt_n  = cnt_q;
        if (pop_intx) begin
            kind_n = kind_q >> 1;
            cnt_n  = cnt_q - CNT_ONE;
        end
        if (intx_evt) begin
            if (cnt_n != CNT_FULL) begin
                kind_n[cnt_n] = intx_asrt;
                cnt_n         = cnt_n + CNT_ONE;
            end else if (intx_asrt == kind_n[0]) begin
                cnt_n = CNT_ONE;
            end else begin
                kind_n[QDEPTH-1] = intx_asrt;
            end
        end
    end

    assign msi_pend_n = (msi_pend_q & ~pop_msi) | msi_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= '0;
            cnt_q      <= '0;
            msi_pend_q <= 1'b0;
        end else begin
            kind_q     <= kind_n;
            cnt_q      <= cnt_n;
            msi_pend_q <= msi_pend_n;
        end
    end

    // Next-state logic.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cnt_q != '0)     state_n = kind_q[0] ? ST_SEND_ASRT : ST_SEND_DSRT;
                else if (msi_pend_q) state_n = ST_SEND_MSI;
            end
            ST_SEND_MSI:  if (msg_ready) state_n = ST_IDLE;
            ST_SEND_ASRT: if (msg_ready) state_n = ST_IDLE;
            ST_SEND_DSRT: if (msg_ready) state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Outputs.
    always_comb begin
        msg_valid = 1'b0;
        msg_type  = MSG_NONE;
        unique case (state_q)
            ST_IDLE:      ;
            ST_SEND_MSI:  begin msg_valid = 1'b1; msg_type = MSG_MSI;  end
            ST_SEND_ASRT: begin msg_valid = 1'b1; msg_type = MSG_ASRT; end
            ST_SEND_DSRT: begin msg_valid = 1'b1; msg_type = MSG_DSRT; end
            default:      ;
        endcase
    end

endmodule

// File: rtl/brg_irq_gen.sv
module brg_irq_gen #(
    parameter int UPSTREAM = 0,
    parameter int SRC_W    = brg_irq_pkg::MAX_SRC,
    parameter int ADDR_W   = 2,
    parameter int QDEPTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_evt,
    input  logic              bw_note_en,
    input  logic              abw_note_en,
    input  logic              msi_en,
    input  logic              intx_dis,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SRC_W-1:0]  reg_wdata,
    output logic [SRC_W-1:0]  reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_type
);

    logic [SRC_W-1:0] evt_g;
    logic [SRC_W-1:0] status_q;
    logic [SRC_W-1:0] mask_q;
    logic             irq_cond;
    logic             msi_evt;
    logic             intx_evt;
    logic             intx_asrt;

    brg_irq_capture #(
        .UPSTREAM (UPSTREAM),
        .SRC_W    (SRC_W),
        .ADDR_W   (ADDR_W)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_evt     (src_evt),
        .bw_note_en  (bw_note_en),
        .abw_note_en (abw_note_en),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .evt_g       (evt_g),
        .status_q    (status_q),
        .mask_q      (mask_q),
        .irq_cond    (irq_cond)
    );

    brg_irq_edge edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_cond  (irq_cond),
        .msi_en    (msi_en),
        .intx_dis  (intx_dis),
        .msi_evt   (msi_evt),
        .intx_evt  (intx_evt),
        .intx_asrt (intx_asrt)
    );

    brg_irq_tx #(
        .QDEPTH (QDEPTH)
    ) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_evt   (msi_evt),
        .intx_evt  (intx_evt),
        .intx_asrt (intx_asrt),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_type  (msg_type)
    );

endmodule

// File: rtl/brg_irq_gen_chk.sv
module brg_irq_gen_chk #(
    parameter int SRC_W  = brg_irq_pkg::MAX_SRC,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [1:0]        msg_type,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [SRC_W-1:0]  reg_wdata,
    input logic [SRC_W-1:0]  evt_g,
    input logic [SRC_W-1:0]  status_q
);

    logic sts_wr;
    assign sts_wr = reg_wr && (reg_addr == ADDR_W'(0));

    // R10: a stalled request stays presented and unchanged.
    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_type));

    // R10: one request at a time; the controller idles after an acceptance.
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    // R6: a presented request always carries a defined message code.
    a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_type != 2'd0);

    // R2: without a clear write, no status bit drops.
    a_r2_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> (status_q & $past(status_q)) == $past(status_q));

    // R3: an event beats a clear of the same bit.
    a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr && ((evt_g & reg_wdata) != '0)
        |=> (status_q & $past(evt_g & reg_wdata)) == $past(evt_g & reg_wdata));

endmodule

bind brg_irq_gen brg_irq_gen_chk #(
    .SRC_W  (SRC_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_type  (msg_type),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt_g     (evt_g),
    .status_q  (status_q)
);

// File: tb/brg_irq_gen_tb_top.sv
module brg_irq_gen_tb_top;

    localparam int SW = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] src_evt = '0;
    logic          bw_note_en = 1'b0;
    logic          abw_note_en = 1'b0;
    logic          msi_en = 1'b0;
    logic          intx_dis = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [SW-1:0] reg_wdata = '0;
    logic [SW-1:0] reg_rdata;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [1:0]    msg_type;

    logic [SW-1:0] u_src_evt = '0;
    logic          u_reg_rd = 1'b0;
    logic [AW-1:0] u_reg_addr = '0;
    logic [SW-1:0] u_reg_rdata;
    logic          u_msg_valid;
    logic [1:0]    u_msg_type;

    int n_chk  = 0;
    int n_fail = 0;
    int rx_cnt = 0;
    bit done   = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    brg_irq_gen #(.UPSTREAM(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .bw_note_en(bw_note_en), .abw_note_en(abw_note_en),
        .msi_en(msi_en), .intx_dis(intx_dis),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type)
    );

    brg_irq_gen #(.UPSTREAM(1)) dut_up_i (
        .clk(clk), .rst_n(rst_n), .src_evt(u_src_evt),
        .bw_note_en(1'b0), .abw_note_en(1'b0),
        .msi_en(1'b0), .intx_dis(1'b0),
        .reg_wr(1'b0), .reg_rd(u_reg_rd), .reg_addr(u_reg_addr),
        .reg_wdata('0), .reg_rdata(u_reg_rdata),
        .msg_valid(u_msg_valid), .msg_ready(1'b1), .msg_type(u_msg_type)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [SW-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [SW-1:0] e, input string tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == e, tag, reg_rdata, e);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [SW-1:0] b);
        @(posedge clk); #1;
        src_evt = b;
        @(posedge clk); #1;
        src_evt = '0;
    endtask

    // Driver side of the scoreboard: predict one message.
    task automatic expect_msg(input logic [1:0] t, input string tag);
        exp_q.push_back(t);
        tag_q.push_back(tag);
        cyc(12);
    endtask

    task automatic expect_none(input string tag);
        int base;
        base = rx_cnt;
        cyc(12);
        chk(rx_cnt == base, tag, rx_cnt - base, 0);
    endtask

    // Monitor side: compare every accepted request against the queue.
    always @(negedge clk) begin
        if (rst_n && !done && msg_valid && msg_ready) begin
            rx_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected message", msg_type, 0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(msg_type == e, t, msg_type, e);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd_chk(2'd0, 4'h0, "R1 status reset");
        rd_chk(2'd1, 4'h7, "R1 mask reset");
        chk(msg_valid == 1'b0, "R1 valid low", msg_valid, 0);

        // R2/R4: masked source sets status but raises nothing
        pulse(4'h1);
        rd_chk(2'd0, 4'h1, "R2 status set");
        expect_none("R4 masked no message");
        wr_reg(2'd0, 4'h1);
        rd_chk(2'd0, 4'h0, "R3 w1c clear");

        // Legacy mode
        wr_reg(2'd1, 4'h0);
        pulse(4'h1);
        expect_msg(2'd2, "R7 assert on rise");
        pulse(4'h1);
        expect_none("R5 repeat inhibited");
        rd_chk(2'd0, 4'h1, "R2 sticky");
        wr_reg(2'd0, 4'h1);
        expect_msg(2'd3, "R8 deassert on clear");

        // MSI mode
        bw_note_en = 1'b1; abw_note_en = 1'b1;
        msi_en = 1'b1;
        pulse(4'h2);
        expect_msg(2'd1, "R6 msi intx enabled");
        wr_reg(2'd0, 4'h2);
        expect_none("R8 no msg on fall msi");
        intx_dis = 1'b1;
        pulse(4'h4);
        expect_msg(2'd1, "R6 msi intx disabled");
        wr_reg(2'd0, 4'h4);
        expect_none("R8 no msg on fall msi2");

        // INTx disabled, MSI off
        msi_en = 1'b0;
        pulse(4'h1);
        expect_none("R7 nothing intx disabled");
        wr_reg(2'd0, 4'h1);
        expect_none("R8 nothing intx disabled");

        // Masking and unmasking
        intx_dis = 1'b0;
        pulse(4'h1);
        expect_msg(2'd2, "R7 assert again");
        wr_reg(2'd1, 4'h1);
        expect_msg(2'd3, "R8 deassert on mask");
        wr_reg(2'd1, 4'h0);
        expect_msg(2'd2, "R4 unmask set bit");
        wr_reg(2'd0, 4'h1);
        expect_msg(2'd3, "R8 deassert after unmask");

        // R9 notification enables
        bw_note_en = 1'b0;
        pulse(4'h2);
        rd_chk(2'd0, 4'h0, "R9 bw gated");
        abw_note_en = 1'b0;
        pulse(4'h4);
        rd_chk(2'd0, 4'h0, "R9 abw gated");
        expect_none("R9 no message when gated");
        bw_note_en = 1'b1;
        pulse(4'h2);
        rd_chk(2'd0, 4'h2, "R9 bw enabled");
        expect_msg(2'd2, "R9 bw assert");
        wr_reg(2'd0, 4'h2);
        expect_msg(2'd3, "R9 bw deassert");

        // R2 unimplemented bit
        pulse(4'h8);
        rd_chk(2'd0, 4'h0, "R2 unimplemented bit");
        expect_none("R2 unimplemented no message");

        // R3 set beats clear in the same cycle
        @(posedge clk); #1;
        src_evt = 4'h1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 4'h1;
        @(posedge clk); #1;
        src_evt = '0; reg_wr = 1'b0;
        rd_chk(2'd0, 4'h1, "R3 set wins");
        expect_msg(2'd2, "R3 assert after set wins");
        wr_reg(2'd0, 4'h1);
        expect_msg(2'd3, "R3 deassert");

        // R10 stall: assert pending, then negation
        msg_ready = 1'b0;
        pulse(4'h1);
        cyc(8);
        chk(msg_valid == 1'b1, "R10 valid held", msg_valid, 1);
        chk(msg_type == 2'd2, "R10 type assert held", msg_type, 2);
        wr_reg(2'd0, 4'h1);
        cyc(8);
        chk(msg_valid == 1'b1 && msg_type == 2'd2, "R10 type stable", msg_type, 2);
        exp_q.push_back(2'd2); tag_q.push_back("R10 first assert");
        exp_q.push_back(2'd3); tag_q.push_back("R10 then deassert");
        @(posedge clk); #1;
        msg_ready = 1'b1;
        cyc(16);
        chk(exp_q.size() == 0, "R10 all delivered", exp_q.size(), 0);

        // R11 upstream source set
        @(posedge clk); #1;
        u_reg_rd = 1'b1; u_reg_addr = 2'd1;
        @(negedge clk);
        chk(u_reg_rdata == 4'hF, "R11 upstream mask reset", u_reg_rdata, 15);
        @(posedge clk); #1;
        u_src_evt = 4'h8; u_reg_addr = 2'd0;
        @(posedge clk); #1;
        u_src_evt = '0;
        @(negedge clk);
        chk(u_reg_rdata == 4'h8, "R11 upstream bit3", u_reg_rdata, 8);
        u_reg_rd = 1'b0;

        cyc(4);
        chk(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule